// File: doc/BRIEF.md
# Serial EEPROM Word Reader

The block fetches one 16-bit word from a three-wire serial EEPROM by driving the device's select, serial clock and data-in lines directly from system-clock logic. A host presents a 6-bit word address, the length of one serial-clock phase in system clocks, and a one-cycle start. The block then performs the whole read transaction and returns the word with a one-cycle done strobe.

The transaction has four parts, each made of phases of equal length:
- **Preamble.** A short select preamble of four phases.
- **Command and address.** A command-and-address shift of nine bits, three phases each.
- **Data capture.** Sixteen bits, two phases each.
- **Release.** One final phase with every device line low.

The whole transaction is always 64 phases long. While idle, all device lines are held low. The returned word stays on its output until the next completed read replaces it.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it, until a start is accepted, ee_cs, ee_sk, ee_di, busy and done are 0 and rd_data is 0.
- R2: A start sampled while busy is low begins a read: busy is high from the next cycle on. The first four phases drive (ee_cs, ee_sk, ee_di) as (0,0,0), (1,0,0), (1,1,0), (0,0,0), in that order.
- R3: The command 3'b110 and then the 6-bit address are each sent most significant bit first. Each bit occupies three phases with ee_cs high and the bit held on ee_di: ee_sk low, then ee_sk high, then ee_sk low.
- R4: Sixteen data bits follow, most significant first. Each bit occupies two phases with ee_cs high and ee_di low: one phase with ee_sk high, then one phase with ee_sk low. ee_do is sampled on the last system clock of the ee_sk-high phase.
- R5: A release phase with all three device lines low ends the read. In the following cycle busy is low, done is high for exactly one cycle, and rd_data carries the captured word.
- R6: One phase lasts phase_len system clocks, with a phase_len of 0 treated as 1. The value is taken when the start is accepted, and later changes to phase_len do not affect the read in progress. A read therefore keeps busy high for exactly 64 phases.
- R7: A start that arrives while busy is high is ignored. The address and phase length presented with it have no effect.
- R8: rd_data changes only in a cycle in which done is high.
- R9: A start given in the cycle in which done is high is accepted, so reads can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a read |
| addr | input | ADDR_W (6) | Word address, taken with an accepted start |
| phase_len | input | DIV_W (8) | System clocks per serial-clock phase, 0 acts as 1 |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle strobe when rd_data is updated |
| rd_data | output | DATA_W (16) | Last word read |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The embedded properties check, on every cycle, a set of local rules:
- done never lasts two cycles.
- Every device line is low whenever busy is low.
- The data-in level does not move during the clock-high and trailing phases of a command bit.
- rd_data holds outside done.
- An idle start always raises busy.
- The latched phase length stays fixed during a read.

The exact ordering of the preamble, the command and address bit values, the sampling point of ee_do and the word assembled from it can only be shown by the bench scenarios. In those scenarios a behavioural device model answers with known words at the extreme addresses, under several phase lengths including zero. The same holds for ignored mid-read starts, back-to-back reads and a reset during a read.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_PRE,
    SEG_CMD,
    SEG_DAT,
    SEG_END
  } seg_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } dev_lines_t;

  localparam int         PRE_STEPS = 4;       // preamble phases
  localparam int         CMD_PH    = 3;       // phases per command/address bit
  localparam int         DAT_PH    = 2;       // phases per data bit
  localparam int         CMD_W     = 3;       // start bit plus opcode
  localparam logic [2:0] READ_CMD  = 3'b110;

endpackage

// File: rtl/ee_rd_rst_sync.sv
module ee_rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ee_rd_phase_timer.sv
module ee_rd_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] len_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] len_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] last;

  assign last   = (len_q == '0) ? '0 : len_q - 1'b1;
  assign tick_o = busy_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (launch_i) begin
      cnt_d = '0;
    end else if (busy_i) begin
      cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (launch_i) begin
        len_q <= len_i;
      end
      cnt_q <= cnt_d;
    end
  end

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(len_q)); // R6

endmodule

// File: rtl/ee_rd_sequencer.sv
module ee_rd_sequencer
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_i,
  input  logic       tick_i,
  output seg_e       seg_o,
  output logic [1:0] ph_o,
  output logic       busy_o,
  output logic       finish_o,
  output logic       cmd_adv_o,
  output logic       dat_smp_o
);

  localparam int CA_W  = CMD_W + ADDR_W;
  localparam int MAXB  = (CA_W > DATA_W) ? CA_W : DATA_W;
  localparam int IDX_W = $clog2(MAXB);

  seg_e             seg_q, seg_d;
  logic [1:0]       ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    seg_d = seg_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    case (seg_q)
      SEG_IDLE: begin
        if (launch_i) begin
          seg_d = SEG_PRE;
          ph_d  = '0;
          idx_d = '0;
        end
      end
      SEG_PRE: begin
        if (tick_i) begin
          if (ph_q == 2'(PRE_STEPS - 1)) begin
            seg_d = SEG_CMD;
            ph_d  = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      SEG_CMD: begin
        if (tick_i) begin
          if (ph_q == 2'(CMD_PH - 1)) begin
            ph_d = '0;
            if (idx_q == IDX_W'(CA_W - 1)) begin
              seg_d = SEG_DAT;
              idx_d = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      SEG_DAT: begin
        if (tick_i) begin
          if (ph_q == 2'(DAT_PH - 1)) begin
            ph_d = '0;
            if (idx_q == IDX_W'(DATA_W - 1)) begin
              seg_d = SEG_END;
              idx_d = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      SEG_END: begin
        if (tick_i) begin
          seg_d = SEG_IDLE;
        end
      end
      default: seg_d = SEG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_IDLE;
      ph_q  <= '0;
      idx_q <= '0;
    end else begin
      seg_q <= seg_d;
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign seg_o     = seg_q;
  assign ph_o      = ph_q;
  assign busy_o    = (seg_q != SEG_IDLE);
  assign finish_o  = tick_i && (seg_q == SEG_END);
  assign cmd_adv_o = tick_i && (seg_q == SEG_CMD) && (ph_q == 2'(CMD_PH - 1));
  assign dat_smp_o = tick_i && (seg_q == SEG_DAT) && (ph_q == 2'd0);

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  phase_len,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int CA_W = CMD_W + ADDR_W;

  logic       rst_sync_n;
  logic       launch;
  logic       tick;
  logic       seq_busy;
  logic       finish;
  logic       cmd_adv;
  logic       dat_smp;
  seg_e       seg;
  logic [1:0] ph;

  logic [CA_W-1:0]   cmdsh_q, cmdsh_d;
  logic [DATA_W-1:0] capsh_q, capsh_d;
  logic [DATA_W-1:0] word_q;
  logic              done_q;
  dev_lines_t        lines;

  ee_rd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign launch = start && !seq_busy;

  ee_rd_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .launch_i (launch),
    .busy_i   (seq_busy),
    .len_i    (phase_len),
    .tick_o   (tick)
  );

  ee_rd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch_i  (launch),
    .tick_i    (tick),
    .seg_o     (seg),
    .ph_o      (ph),
    .busy_o    (seq_busy),
    .finish_o  (finish),
    .cmd_adv_o (cmd_adv),
    .dat_smp_o (dat_smp)
  );

  // next-state of the shift registers
  always_comb begin
    cmdsh_d = cmdsh_q;
    capsh_d = capsh_q;
    if (launch) begin
      cmdsh_d = {READ_CMD, addr};
      capsh_d = '0;
    end else begin
      if (cmd_adv) begin
        cmdsh_d = {cmdsh_q[CA_W-2:0], 1'b0};
      end
      if (dat_smp) begin
        capsh_d = {capsh_q[DATA_W-2:0], ee_do};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmdsh_q <= '0;
      capsh_q <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      cmdsh_q <= cmdsh_d;
      capsh_q <= capsh_d;
      if (finish) begin
        word_q <= capsh_q;
      end
      done_q <= finish;
    end
  end

  // device line decode from sequencer state
  always_comb begin
    lines = '0;
    case (seg)
      SEG_PRE: begin
        lines.cs = (ph == 2'd1) || (ph == 2'd2);
        lines.sk = (ph == 2'd2);
      end
      SEG_CMD: begin
        lines.cs = 1'b1;
        lines.sk = (ph == 2'd1);
        lines.di = cmdsh_q[CA_W-1];
      end
      SEG_DAT: begin
        lines.cs = 1'b1;
        lines.sk = (ph == 2'd0);
      end
      default: lines = '0;
    endcase
  end

  assign ee_cs   = lines.cs;
  assign ee_sk   = lines.sk;
  assign ee_di   = lines.di;
  assign busy    = seq_busy;
  assign done    = done_q;
  assign rd_data = word_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !(ee_cs || ee_sk || ee_di)); // R1
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> $stable(rd_data)); // R8
  AST_CMD_DI_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seg == SEG_CMD && ph != 2'd0) |-> $stable(ee_di)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy) |=> busy); // R2

endmodule

// File: tb/ee_word_reader_bench.sv
module ee_word_reader_bench;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ln_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  plen = 8'd1;
  logic        ee_do = 1'b0;
  logic        busy, done, ee_cs, ee_sk, ee_di;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  ln_t         q[$];
  string       tq[$];
  bit          done_exp = 0;
  logic [15:0] rd_exp = '0;
  logic [15:0] pend_word = '0;
  logic [5:0]  pend_addr = '0;

  // device model state
  bit          dev_on = 0;
  int          dev_cnt = 0;
  logic [2:0]  dev_cmd = '0;
  logic [5:0]  dev_addr = '0;

  always #2 clk = ~clk;

  ee_word_reader u_ee_word_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addr      (addr),
    .phase_len (plen),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .ee_do     (ee_do)
  );

  function automatic logic [15:0] mem_word(input logic [5:0] a);
    logic [15:0] m;
    m = 16'h1357 * {10'd0, a};
    return 16'hA5C3 ^ m ^ {a, a[3:0], a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural serial EEPROM
  always @(negedge ee_cs) begin
    dev_on  = 0;
    dev_cnt = 0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (!dev_on) begin
        if (ee_di) begin
          dev_on  = 1;
          dev_cnt = 1;
          dev_cmd = 3'b001;
        end
      end else begin
        dev_cnt++;
        if (dev_cnt <= 3) dev_cmd = {dev_cmd[1:0], ee_di};
        else if (dev_cnt <= 9) dev_addr = {dev_addr[4:0], ee_di};
        else if (dev_cnt <= 25) begin
          logic [15:0] w;
          w = mem_word(dev_addr);
          ee_do = w[25 - dev_cnt];
        end
      end
    end
  end

  task automatic push_step(input logic cs, input logic sk, input logic di,
                           input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      q.push_back('{cs: cs, sk: sk, di: di});
      tq.push_back(tag);
    end
  endtask

  task automatic enqueue(input logic [5:0] a, input logic [7:0] len);
    int n;
    logic [8:0] ca;
    n  = (len == 0) ? 1 : int'(len);
    ca = {3'b110, a};
    push_step(0, 0, 0, n, "R2");
    push_step(1, 0, 0, n, "R2");
    push_step(1, 1, 0, n, "R2");
    push_step(0, 0, 0, n, "R2");
    for (int b = 8; b >= 0; b--) begin
      push_step(1, 0, ca[b], n, "R3");
      push_step(1, 1, ca[b], n, "R3");
      push_step(1, 0, ca[b], n, "R3");
    end
    for (int b = 0; b < 16; b++) begin
      push_step(1, 1, 0, n, "R4");
      push_step(1, 0, 0, n, "R4");
    end
    push_step(0, 0, 0, n, "R5");
    pend_word = mem_word(a);
    pend_addr = a;
  endtask

  // reference model, advanced once per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      tq.delete();
      done_exp = 0;
      rd_exp   = '0;
    end else begin
      done_exp = 0;
      if (q.size() != 0) begin
        void'(q.pop_front());
        void'(tq.pop_front());
        if (q.size() == 0) begin
          done_exp = 1;
          rd_exp   = pend_word;
        end
      end else if (start) begin
        enqueue(addr, plen);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      ln_t   e;
      string tag;
      e   = (q.size() != 0) ? q[0] : '0;
      tag = (q.size() != 0) ? tq[0] : "R1";
      chk(busy == (q.size() != 0), "R6", "busy", busy, q.size() != 0);
      chk({ee_cs, ee_sk, ee_di} == e, tag, "cs/sk/di", {ee_cs, ee_sk, ee_di}, e);
      chk(done == done_exp, "R5", "done", done, done_exp);
      chk(rd_data == rd_exp, done_exp ? "R4" : "R8", "rd_data", rd_data, rd_exp);
      if (done_exp) begin
        chk(dev_cmd == 3'b110, "R3", "command seen by device", dev_cmd, 3'b110);
        chk(dev_addr == pend_addr, "R3", "address seen by device", dev_addr, pend_addr);
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_exp);
  endtask

  task automatic read(input logic [5:0] a, input logic [7:0] len);
    @(negedge clk);
    start = 1; addr = a; plen = len;
    @(negedge clk);
    start = 0;
    wait_done();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({busy, done, ee_cs, ee_sk, ee_di} == 5'b0, "R1", "lines in reset",
        {busy, done, ee_cs, ee_sk, ee_di}, 0);
    chk(rd_data == 16'h0, "R1", "rd_data in reset", rd_data, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // main reads at extreme and mixed addresses, several phase lengths
    read(6'd0, 8'd1);
    read(6'd63, 8'd3);
    read(6'd42, 8'd0);    // R6: zero acts as one

    // R7 and R6: starts while busy are ignored, phase length latched
    @(negedge clk);
    start = 1; addr = 6'd21; plen = 8'd2;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    start = 1; addr = 6'd5; plen = 8'd7;
    @(negedge clk);
    start = 0;
    repeat (60) @(negedge clk);
    start = 1; addr = 6'd9;
    @(negedge clk);
    start = 0;
    wait_done();
    chk(rd_data == mem_word(6'd21), "R7", "word after ignored starts", rd_data, mem_word(6'd21));
    @(negedge clk);
    chk(busy == 1'b0, "R7", "no extra read started", busy, 0);

    // R9: back-to-back start in the done cycle
    plen = 8'd1;
    read(6'd7, 8'd1);
    start = 1; addr = 6'd56;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9", "busy after start in done cycle", busy, 1);
    wait_done();
    chk(rd_data == mem_word(6'd56), "R9", "second word", rd_data, mem_word(6'd56));

    // R1: asynchronous reset in the middle of a read
    @(negedge clk);
    start = 1; addr = 6'd33; plen = 8'd2;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    #1 rst_n = 0;
    #0.5;
    chk({busy, ee_cs, ee_sk, ee_di} == 4'b0, "R1", "lines at reset assert",
        {busy, ee_cs, ee_sk, ee_di}, 0);
    chk(rd_data == 16'h0, "R1", "rd_data at reset assert", rd_data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    read(6'd33, 8'd2);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule